// File: doc/BRIEF.md
# Periodic ADC Conversion and Readout Sequencer

This block runs a four-channel 18-bit successive-approximation ADC without any processor help. A free-running period counter sets the pace. On each period the block raises a conversion-start pulse of fixed width and waits a set conversion time. It then pulls chip select low, waits a set lead time and clocks in 96 bits as an SPI master in mode 0: SCLK idles low and MISO is sampled on the rising edge, most significant bit first.

The serial stream is gathered as 8-bit characters, and three characters make one 24-bit result word. Each word is split into an 18-bit sample, a 3-bit channel identifier and a 3-bit span code. The received identifier is compared with the slot the word arrived in (0 to 3), and a mismatch is both tagged on that word and latched in a sticky flag. Words leave on a valid/ready stream, so a DMA-style sink can collect them directly. The stream has one holding register. If a word completes while the previous one is still waiting, the new word is dropped and a sticky overrun flag is set, and the conversion rhythm is not disturbed.

The sequencer walks through five named states:
- `SQ_IDLE` goes to `SQ_CNV` on a period tick.
- `SQ_CNV` goes to `SQ_CONVERT` when the pulse width is reached.
- `SQ_CONVERT` goes to `SQ_CS_SETUP` when the conversion wait expires.
- `SQ_CS_SETUP` goes to `SQ_READ` when the lead time expires, and this transition also starts the serial engine.
- `SQ_READ` goes back to `SQ_IDLE` when the engine reports done.

Top module: `adc_scan_sequencer`

## Requirements
- R1: The conversion-start output rises once every PERIOD_CYC clock cycles, whatever the output stream does. After reset is released it first rises on the first clock edge at which reset is sampled high. A period tick only occurs while the sequencer is idle.
- R2: The conversion-start output stays high for exactly CNV_HIGH_CYC clock cycles.
- R3: Chip select (active low) falls exactly CONV_WAIT_CYC cycles after the conversion-start output falls. Chip select is never low while the conversion-start output is high.
- R4: The first rising SCLK edge comes CS_LEAD_CYC + SCLK_HALF_CYC cycles after chip select falls. SCLK is low whenever chip select is high.
- R5: Each readout makes exactly 96 rising SCLK edges, and each high phase of SCLK lasts SCLK_HALF_CYC cycles. MISO is sampled on the rising edge.
- R6: Each 24-bit word is formed MSB first from three 8-bit characters. Bits 23:6 are presented as the sample, bits 5:3 as the channel identifier and bits 2:0 as the span code.
- R7: Words of a readout are offered in arrival order (slots 0, 1, 2, 3). While valid is high and ready is low, valid and all word fields hold.
- R8: When the received identifier differs from the arrival slot, the error tag on that word is 1 and the sticky error flag becomes 1 and stays 1 until reset. Matching words carry a tag of 0.
- R9: A word that completes while valid is high and ready is low is discarded. The held word is kept and the sticky overrun flag becomes 1 and stays 1 until reset.
- R10: While the active-low synchronous reset is low, the conversion-start output and SCLK are low, chip select is high, valid is low and both sticky flags are clear. The period count restarts from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_o | output | 1 | Conversion-start pulse to the ADC |
| cs_n_o | output | 1 | SPI chip select, active low |
| sclk_o | output | 1 | SPI serial clock, idle low |
| miso_i | input | 1 | SPI serial data from the ADC |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Sink ready to take the word |
| m_sample | output | 18 | Sample field of the word |
| m_chan | output | 3 | Received channel identifier |
| m_span | output | 3 | Span code of the word |
| m_id_err | output | 1 | Identifier did not match the arrival slot |
| err_sticky_o | output | 1 | Sticky identifier-mismatch flag |
| overrun_o | output | 1 | Sticky dropped-word flag |

## Verification
Properties check on every cycle that:
- the conversion pulse has its exact width;
- the pulse and chip select never overlap;
- SCLK stays low whenever chip select is high;
- a stalled word holds;
- both sticky flags stay set once set;
- a period tick arrives only while the interface is quiet.

Only the bench's scenarios can show the rest. These are the exact period across a stalled sink and across a mid-readout reset, the conversion and lead delays, the bit count per readout, and the bit-accurate field split against a modelled ADC, including all-ones and all-zero samples. The same scenarios cover the tagging of a planted wrong identifier and which words survive an overrun.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SAMPLE_W = 18;
    localparam int ID_W     = 3;
    localparam int SPAN_W   = 3;
    localparam int WORD_W   = SAMPLE_W + ID_W + SPAN_W;

    // Field layout of one result word, most significant field first
    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        logic [ID_W-1:0]     chan;
        logic [SPAN_W-1:0]   span;
    } adc_word_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CNV,
        SQ_CONVERT,
        SQ_CS_SETUP,
        SQ_READ
    } seq_state_t;

endpackage

// File: rtl/adc_seq_ticker.sv
module adc_seq_ticker #(
    parameter int PERIOD_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_spi_rx.sv
module adc_seq_spi_rx #(
    parameter int SCLK_HALF_CYC  = 4,
    parameter int CHAR_W         = 8,
    parameter int CHARS_PER_WORD = 3,
    parameter int N_WORDS        = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic                               miso_i,
    output logic                               sclk_o,
    output logic                               word_stb,
    output logic [CHAR_W*CHARS_PER_WORD-1:0]   word_o,
    output logic [$clog2(N_WORDS)-1:0]         idx_o,
    output logic                               done
);

    localparam int ACC_W = (CHARS_PER_WORD - 1) * CHAR_W;
    localparam int DIV_W = (SCLK_HALF_CYC > 1) ? $clog2(SCLK_HALF_CYC) : 1;
    localparam int BIT_W = $clog2(CHAR_W);
    localparam int CH_W  = (CHARS_PER_WORD > 1) ? $clog2(CHARS_PER_WORD) : 1;
    localparam int WD_W  = $clog2(N_WORDS + 1);
    localparam int IDX_W = $clog2(N_WORDS);

    logic              busy_q;
    logic              sclk_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic [CH_W-1:0]   chr_q;
    logic [WD_W-1:0]   words_q;
    logic [CHAR_W-1:0] char_sr_q;
    logic [ACC_W-1:0]  acc_q;
    logic [CHAR_W-1:0] char_next;
    logic              div_hit;
    logic              rise_now;
    logic              fall_now;

    always_comb begin
        char_next = {char_sr_q[CHAR_W-2:0], miso_i};
        div_hit   = (div_q == DIV_W'(SCLK_HALF_CYC - 1));
        rise_now  = busy_q && div_hit && !sclk_q;
        fall_now  = busy_q && div_hit && sclk_q;
    end

    // Half-period divider and edge generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            div_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                sclk_q <= 1'b0;
                div_q  <= '0;
            end else if (busy_q) begin
                div_q <= div_hit ? '0 : div_q + 1'b1;
                if (rise_now) begin
                    sclk_q <= 1'b1;
                end else if (fall_now) begin
                    sclk_q <= 1'b0;
                    if (words_q == WD_W'(N_WORDS)) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    // Character gathering and word assembly on rising SCLK
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q     <= '0;
            chr_q     <= '0;
            words_q   <= '0;
            char_sr_q <= '0;
            acc_q     <= '0;
            word_stb  <= 1'b0;
            word_o    <= '0;
            idx_o     <= '0;
        end else begin
            word_stb <= 1'b0;
            if (start) begin
                bit_q   <= '0;
                chr_q   <= '0;
                words_q <= '0;
            end else if (rise_now) begin
                if (bit_q == BIT_W'(CHAR_W - 1)) begin
                    bit_q <= '0;
                    if (chr_q == CH_W'(CHARS_PER_WORD - 1)) begin
                        chr_q    <= '0;
                        word_o   <= {acc_q, char_next};
                        idx_o    <= words_q[IDX_W-1:0];
                        word_stb <= 1'b1;
                        words_q  <= words_q + 1'b1;
                    end else begin
                        chr_q <= chr_q + 1'b1;
                        acc_q <= ACC_W'({acc_q, char_next});
                    end
                end else begin
                    bit_q     <= bit_q + 1'b1;
                    char_sr_q <= char_next;
                end
            end
        end
    end

    assign sclk_o = sclk_q;

endmodule

// File: rtl/adc_seq_out_stage.sv
module adc_seq_out_stage import adc_seq_pkg::*; #(
    parameter int N_CHAN = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      word_stb,
    input  logic [WORD_W-1:0]         word_i,
    input  logic [$clog2(N_CHAN)-1:0] idx_i,
    input  logic                      m_ready,
    output logic                      m_valid,
    output logic [SAMPLE_W-1:0]       m_sample,
    output logic [ID_W-1:0]           m_chan,
    output logic [SPAN_W-1:0]         m_span,
    output logic                      m_id_err,
    output logic                      err_sticky_o,
    output logic                      overrun_o
);

    adc_word_t fields;
    logic      mismatch;
    logic      stalled;

    always_comb begin
        fields   = adc_word_t'(word_i);
        mismatch = (fields.chan != ID_W'(idx_i));
        stalled  = m_valid && !m_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid      <= 1'b0;
            m_sample     <= '0;
            m_chan       <= '0;
            m_span       <= '0;
            m_id_err     <= 1'b0;
            err_sticky_o <= 1'b0;
            overrun_o    <= 1'b0;
        end else begin
            if (word_stb && mismatch) begin
                err_sticky_o <= 1'b1;
            end
            if (word_stb && stalled) begin
                overrun_o <= 1'b1;
            end else if (word_stb) begin
                m_valid  <= 1'b1;
                m_sample <= fields.sample;
                m_chan   <= fields.chan;
                m_span   <= fields.span;
                m_id_err <= mismatch;
            end else if (m_ready) begin
                m_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer import adc_seq_pkg::*; #(
    parameter int PERIOD_CYC     = 2500,
    parameter int CNV_HIGH_CYC   = 4,
    parameter int CONV_WAIT_CYC  = 60,
    parameter int CS_LEAD_CYC    = 2,
    parameter int SCLK_HALF_CYC  = 4,
    parameter int N_CHAN         = 4,
    parameter int CHAR_W         = 8,
    parameter int CHARS_PER_WORD = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                cnv_o,
    output logic                cs_n_o,
    output logic                sclk_o,
    input  logic                miso_i,
    output logic                m_valid,
    input  logic                m_ready,
    output logic [SAMPLE_W-1:0] m_sample,
    output logic [ID_W-1:0]     m_chan,
    output logic [SPAN_W-1:0]   m_span,
    output logic                m_id_err,
    output logic                err_sticky_o,
    output logic                overrun_o
);

    localparam int PH_A   = (CNV_HIGH_CYC > CONV_WAIT_CYC) ? CNV_HIGH_CYC : CONV_WAIT_CYC;
    localparam int PH_MAX = (PH_A > CS_LEAD_CYC) ? PH_A : CS_LEAD_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int IDX_W  = $clog2(N_CHAN);

    seq_state_t             state_q;
    seq_state_t             state_d;
    logic [PH_W-1:0]        phase_q;
    logic                   period_tick;
    logic                   spi_start;
    logic                   spi_done;
    logic                   word_stb;
    logic [WORD_W-1:0]      word_bits;
    logic [IDX_W-1:0]       word_idx;

    adc_seq_ticker #(
        .PERIOD_CYC(PERIOD_CYC)
    ) u_ticker (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (period_tick)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:     if (period_tick)                         state_d = SQ_CNV;
            SQ_CNV:      if (phase_q == PH_W'(CNV_HIGH_CYC - 1))  state_d = SQ_CONVERT;
            SQ_CONVERT:  if (phase_q == PH_W'(CONV_WAIT_CYC - 1)) state_d = SQ_CS_SETUP;
            SQ_CS_SETUP: if (phase_q == PH_W'(CS_LEAD_CYC - 1))   state_d = SQ_READ;
            SQ_READ:     if (spi_done)                            state_d = SQ_IDLE;
            default:                                              state_d = SQ_IDLE;
        endcase
    end

    // State register with the in-state phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= (state_d != state_q) ? '0 : phase_q + 1'b1;
        end
    end

    // Moore outputs decoded from the state register
    always_comb begin
        cnv_o     = (state_q == SQ_CNV);
        cs_n_o    = !((state_q == SQ_CS_SETUP) || (state_q == SQ_READ));
        spi_start = (state_q == SQ_CS_SETUP) && (state_d == SQ_READ);
    end

    adc_seq_spi_rx #(
        .SCLK_HALF_CYC (SCLK_HALF_CYC),
        .CHAR_W        (CHAR_W),
        .CHARS_PER_WORD(CHARS_PER_WORD),
        .N_WORDS       (N_CHAN)
    ) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (spi_start),
        .miso_i  (miso_i),
        .sclk_o  (sclk_o),
        .word_stb(word_stb),
        .word_o  (word_bits),
        .idx_o   (word_idx),
        .done    (spi_done)
    );

    adc_seq_out_stage #(
        .N_CHAN(N_CHAN)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_stb    (word_stb),
        .word_i      (word_bits),
        .idx_i       (word_idx),
        .m_ready     (m_ready),
        .m_valid     (m_valid),
        .m_sample    (m_sample),
        .m_chan      (m_chan),
        .m_span      (m_span),
        .m_id_err    (m_id_err),
        .err_sticky_o(err_sticky_o),
        .overrun_o   (overrun_o)
    );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker import adc_seq_pkg::*; #(
    parameter int CNV_HIGH_CYC = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cnv_o,
    input logic                cs_n_o,
    input logic                sclk_o,
    input logic                m_valid,
    input logic                m_ready,
    input logic [SAMPLE_W-1:0] m_sample,
    input logic [ID_W-1:0]     m_chan,
    input logic [SPAN_W-1:0]   m_span,
    input logic                m_id_err,
    input logic                err_sticky_o,
    input logic                overrun_o,
    input logic                tick
);

    logic [15:0] high_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_run <= '0;
        end else if (cnv_o) begin
            high_run <= (high_run == 16'hFFFF) ? high_run : high_run + 1'b1;
        end else begin
            high_run <= '0;
        end
    end

    AST_TICK_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (!cnv_o && cs_n_o)); // R1
    AST_CNV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_o) |-> (high_run == 16'(CNV_HIGH_CYC))); // R2
    AST_CNV_CS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_o |-> cs_n_o); // R3
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o); // R4
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable({m_sample, m_chan, m_span, m_id_err}))); // R7
    AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky_o |=> err_sticky_o); // R8
    AST_OVERRUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o); // R9

endmodule

bind adc_scan_sequencer adc_seq_checker #(
    .CNV_HIGH_CYC(CNV_HIGH_CYC)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnv_o       (cnv_o),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_sample    (m_sample),
    .m_chan      (m_chan),
    .m_span      (m_span),
    .m_id_err    (m_id_err),
    .err_sticky_o(err_sticky_o),
    .overrun_o   (overrun_o),
    .tick        (period_tick)
);

// File: tb/adc_scan_sequencer_test.sv
`timescale 1ns/1ps
module adc_scan_sequencer_test;

    localparam int T        = 20;
    localparam int PERIOD   = 300;
    localparam int CNV_HIGH = 4;
    localparam int CONV     = 20;
    localparam int LEAD     = 3;
    localparam int HALF     = 1;
    localparam int NBITS    = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miso = 1'b0;
    logic        m_ready = 1'b0;
    logic        cnv_o, cs_n_o, sclk_o, m_valid, m_id_err, err_sticky_o, overrun_o;
    logic [17:0] m_sample;
    logic [2:0]  m_chan, m_span;

    always #(T/2) clk = ~clk;

    adc_scan_sequencer #(
        .PERIOD_CYC(PERIOD), .CNV_HIGH_CYC(CNV_HIGH), .CONV_WAIT_CYC(CONV),
        .CS_LEAD_CYC(LEAD), .SCLK_HALF_CYC(HALF), .N_CHAN(4),
        .CHAR_W(8), .CHARS_PER_WORD(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cnv_o(cnv_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .miso_i(miso), .m_valid(m_valid), .m_ready(m_ready), .m_sample(m_sample),
        .m_chan(m_chan), .m_span(m_span), .m_id_err(m_id_err),
        .err_sticky_o(err_sticky_o), .overrun_o(overrun_o)
    );

    int checks = 0;
    int errs = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ADC data model
    function automatic logic [17:0] smp(int f, int c);
        if (f == 0 && c == 0) return 18'h3FFFF;
        if (f == 0 && c == 1) return 18'h00000;
        return 18'((f * 4 + c) * 32'h2345 + 32'h1F0F1);
    endfunction
    function automatic logic [2:0] idv(int f, int c);
        return (f == 3 && c == 2) ? 3'd5 : 3'(c);
    endfunction
    function automatic logic [2:0] spn(int f, int c);
        return 3'(f + c);
    endfunction

    int          model_f = 0;
    int          bp = 0;
    bit          model_low = 0;
    logic [95:0] fb;

    always @(negedge cs_n_o) begin
        if (rst_n === 1'b1) begin
            for (int c = 0; c < 4; c++) fb[95 - 24*c -: 24] = {smp(model_f, c), idv(model_f, c), spn(model_f, c)};
            bp = 95;
            miso = fb[95];
            model_low = 1;
        end
    end
    always @(negedge sclk_o) begin
        if (cs_n_o === 1'b0 && bp > 0) begin
            bp--;
            miso = fb[bp];
        end
    end
    always @(posedge cs_n_o) begin
        if (model_low && rst_n === 1'b1) model_f++;
        model_low = 0;
    end

    // Timing monitors
    time t_cr, t_cf, t_csf, t_sr;
    bit  have_prev = 0, cnv_up = 0, sclk_first = 0, cs_lo = 0;
    int  n_cnv = 0, n_csr = 0, sclk_n = 0;

    always @(posedge cnv_o) begin
        if (have_prev) chk("R1", "period cycles", ($time - t_cr) / T, PERIOD);
        t_cr = $time;
        have_prev = 1;
        cnv_up = 1;
        n_cnv++;
    end
    always @(negedge cnv_o) begin
        if (cnv_up) begin
            chk("R2", "cnv high cycles", ($time - t_cr) / T, CNV_HIGH);
            t_cf = $time;
            cnv_up = 0;
        end
    end
    always @(negedge cs_n_o) begin
        if (rst_n === 1'b1) begin
            chk("R3", "cnv fall to cs fall", ($time - t_cf) / T, CONV);
            t_csf = $time;
            sclk_first = 1;
            sclk_n = 0;
            cs_lo = 1;
        end
    end
    always @(posedge sclk_o) begin
        if (cs_lo) begin
            if (sclk_first) chk("R4", "cs fall to first sclk rise", ($time - t_csf) / T, LEAD + HALF);
            sclk_first = 0;
            sclk_n++;
            t_sr = $time;
        end
    end
    always @(negedge sclk_o) begin
        if (cs_lo && rst_n === 1'b1) chk("R5", "sclk high cycles", ($time - t_sr) / T, HALF);
    end
    always @(posedge cs_n_o) begin
        if (cs_lo) begin
            cs_lo = 0;
            if (rst_n === 1'b1) begin
                chk("R5", "sclk rises per readout", sclk_n, NBITS);
                n_csr++;
            end
        end
    end

    // Stream collector
    int ef = 0, ec = 0, n_acc = 0;
    bit coll_en = 1;

    always @(negedge clk) begin
        if (rst_n && coll_en && m_valid && m_ready) begin
            chk("R6", "sample field", m_sample, smp(ef, ec));
            chk("R6", "span field", m_span, spn(ef, ec));
            chk("R7", "channel id in order", m_chan, idv(ef, ec));
            chk("R8", "id error tag", m_id_err, (ef == 3 && ec == 2) ? 1 : 0);
            n_acc++;
            if (ef == 4) begin
                ef = 5;
                ec = 0;
            end else if (ec == 3) begin
                ec = 0;
                ef++;
            end else begin
                ec++;
            end
        end
    end

    task automatic idle_checks(input string tag);
        chk("R10", {tag, " cnv low"}, cnv_o, 0);
        chk("R10", {tag, " cs high"}, cs_n_o, 1);
        chk("R10", {tag, " sclk low"}, sclk_o, 0);
        chk("R10", {tag, " valid low"}, m_valid, 0);
        chk("R10", {tag, " error flag clear"}, err_sticky_o, 0);
        chk("R10", {tag, " overrun clear"}, overrun_o, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 0;
        m_ready = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        idle_checks("initial reset");
        @(posedge clk); #1;
        rst_n = 1;
        m_ready = 1;
        @(posedge clk); #1;
        chk("R1", "cnv high one edge after release", cnv_o, 1);

        wait (n_cnv == 4); #1;
        chk("R8", "error flag clear before bad id", err_sticky_o, 0);

        wait (n_cnv == 5);
        @(posedge clk); #1;
        chk("R8", "error flag set after bad id", err_sticky_o, 1);
        chk("R9", "overrun clear before stall", overrun_o, 0);
        m_ready = 0;

        wait (n_csr == 5);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9", "overrun set after stall", overrun_o, 1);
        chk("R7", "valid held during stall", m_valid, 1);
        chk("R9", "held word is first of frame", m_chan, 0);
        chk("R9", "held sample kept", m_sample, smp(4, 0));
        @(posedge clk); #1;
        m_ready = 1;

        wait (n_csr == 7);
        repeat (5) @(posedge clk); #1;
        coll_en = 0;
        chk("R9", "words accepted with three dropped", n_acc, 25);
        chk("R8", "error flag still set", err_sticky_o, 1);

        // Reset in the middle of a readout
        wait (n_cnv == 8);
        wait (cs_n_o == 1'b0);
        repeat (40) @(posedge clk); #1;
        rst_n = 0;
        have_prev = 0;
        cnv_up = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_checks("mid-readout reset");
        @(posedge clk); #1;
        rst_n = 1;
        @(posedge clk); #1;
        chk("R10", "period restarts after reset", cnv_o, 1);
        wait (n_cnv == 10);
        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule